// File: doc/BRIEF.md
# Two-Path Interrupt Steering Controller

This block gathers a set of level-sensitive interrupt sources (32 by default) and routes each one, bit by bit, to either a normal interrupt line or a fast interrupt line. Software reaches it through a word-wide register port with separate read and write strobes. The port exposes the live source levels, a per-source enable mask, a per-source path choice, the masked status of each path, and, for each path, the number of the most urgent source currently asserting.

Nothing is latched inside the controller. The raw status is the live source vector, so an interrupt is cleared at its source. Urgency is fixed by source number: a higher number wins. A scratch priority register can be read and written, but it has no effect on that ordering.

Top module: `dpic_top`

## Requirements
- R1: After reset, the enable, path-select and priority registers read zero, and both interrupt outputs are low.
- R2: A read of offset 0x00 returns the current source vector, including changes made since the previous cycle. The block holds no latched copy.
- R3: A write to offset 0x04 sets the enable mask, and a write to 0x08 sets the path select. A later read of either offset returns the value written.
- R4: A read of offset 0x0C returns sources & enable & ~select. A select bit of 0 sends that source to the normal path.
- R5: A read of offset 0x10 returns sources & enable & select. A select bit of 1 sends that source to the fast path.
- R6: The `irq` output is high exactly when the normal-path status is nonzero. The `fiq` output is high exactly when the fast-path status is nonzero.
- R7: Offset 0x18 returns the index of the highest-numbered set bit of the normal-path status in bits [5:0]. Offset 0x1C does the same for the fast-path status. Both return 0 when their path is empty.
- R8: Offset 0x14 reads back the last value written to it. That value has no effect on any status, highest-index readout or output.
- R9: Reads of any unmapped offset return zero. Writes to read-only or unmapped offsets change no register.
- R10: `rd_data` is combinational in the same cycle as the read strobe. A register write takes effect on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src | input | NSRC | Level-sensitive interrupt sources |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW | Byte offset of the word accessed |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, zero when rd_en is low |
| irq | output | 1 | Normal-path interrupt |
| fiq | output | 1 | Fast-path interrupt |

## Verification
The bench uses three families of source pattern:
- Every single-hot source is swept under all four combinations of its enable and select bits. This separates masking errors from routing errors and checks each possible winning index.
- Patterns with two set bits, one low and one high, confirm that the higher number wins. Placing the two bits on opposite paths shows that each path resolves its own winner.
- Walking-ones patterns in the scratch register and writes to the read-only offsets show that neither changes the status, the outputs or the stored masks. Reads of unmapped offsets complete the check.

// File: rtl/dpic_pkg.sv
package dpic_pkg;
  localparam int unsigned OFS_RAW   = 'h00;
  localparam int unsigned OFS_ENA   = 'h04;
  localparam int unsigned OFS_SEL   = 'h08;
  localparam int unsigned OFS_NSTAT = 'h0C;
  localparam int unsigned OFS_FSTAT = 'h10;
  localparam int unsigned OFS_PRIO  = 'h14;
  localparam int unsigned OFS_NTOP  = 'h18;
  localparam int unsigned OFS_FTOP  = 'h1C;

  typedef struct packed {
    logic ena;
    logic sel;
    logic prio;
  } wr_hit_t;
endpackage

// File: rtl/dpic_regs.sv
module dpic_regs #(
  parameter int NSRC = 32,
  parameter int DW   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpic_pkg::wr_hit_t hit,
  input  logic [DW-1:0]    wr_data,
  output logic [NSRC-1:0]  ena_q,
  output logic [NSRC-1:0]  sel_q,
  output logic [DW-1:0]    prio_q
);
  logic [NSRC-1:0] ena_d, sel_d;
  logic [DW-1:0]   prio_d;

  always_comb begin
    ena_d  = ena_q;
    sel_d  = sel_q;
    prio_d = prio_q;
    if (hit.ena)  ena_d  = wr_data[NSRC-1:0];
    if (hit.sel)  sel_d  = wr_data[NSRC-1:0];
    if (hit.prio) prio_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q  <= '0;
      sel_q  <= '0;
      prio_q <= '0;
    end else begin
      if (hit.ena)  ena_q  <= ena_d;
      if (hit.sel)  sel_q  <= sel_d;
      if (hit.prio) prio_q <= prio_d;
    end
  end
endmodule

// File: rtl/dpic_top_find.sv
module dpic_top_find #(
  parameter int NSRC = 32,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] vec,
  output logic [IW-1:0]   idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < NSRC; i++)
      if (vec[i]) idx = IW'(i);
  end
endmodule

// File: rtl/dpic_top.sv
module dpic_top #(
  parameter int NSRC = 32,
  parameter int AW   = 6,
  localparam int DW  = 32,
  localparam int IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   rd_data,
  output logic            irq,
  output logic            fiq
);
  import dpic_pkg::*;

  wr_hit_t          hit;
  logic [NSRC-1:0]  ena_q, sel_q, nstat, fstat;
  logic [DW-1:0]    prio_q;
  logic [IW-1:0]    ntop, ftop;

  always_comb begin
    hit.ena  = wr_en && (addr == AW'(OFS_ENA));
    hit.sel  = wr_en && (addr == AW'(OFS_SEL));
    hit.prio = wr_en && (addr == AW'(OFS_PRIO));
  end

  dpic_regs #(.NSRC(NSRC), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .hit(hit), .wr_data(wr_data),
    .ena_q(ena_q), .sel_q(sel_q), .prio_q(prio_q)
  );

  assign nstat = src & ena_q & ~sel_q;
  assign fstat = src & ena_q & sel_q;
  assign irq   = |nstat;
  assign fiq   = |fstat;

  dpic_top_find #(.NSRC(NSRC)) u_nfind (.vec(nstat), .idx(ntop));
  dpic_top_find #(.NSRC(NSRC)) u_ffind (.vec(fstat), .idx(ftop));

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (addr)
        AW'(OFS_RAW):   rd_data = DW'(src);
        AW'(OFS_ENA):   rd_data = DW'(ena_q);
        AW'(OFS_SEL):   rd_data = DW'(sel_q);
        AW'(OFS_NSTAT): rd_data = DW'(nstat);
        AW'(OFS_FSTAT): rd_data = DW'(fstat);
        AW'(OFS_PRIO):  rd_data = prio_q;
        AW'(OFS_NTOP):  rd_data = DW'(ntop);
        AW'(OFS_FTOP):  rd_data = DW'(ftop);
        default:        rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/dpic_checker.sv
module dpic_checker #(
  parameter int NSRC = 32,
  parameter int AW   = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src,
  input logic            wr_en,
  input logic            rd_en,
  input logic [AW-1:0]   addr,
  input logic [31:0]     wr_data,
  input logic [31:0]     rd_data,
  input logic            irq,
  input logic            fiq,
  input logic [NSRC-1:0] ena_q,
  input logic [NSRC-1:0] sel_q
);
  assert_paths_disjoint_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && fiq && $onehot(src & ena_q)));
  assert_irq_needs_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |(src & ena_q & ~sel_q));
  assert_fiq_needs_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fiq |-> |(src & ena_q & sel_q));
  assert_idle_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rd_data == '0);
  assert_ena_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == AW'('h04)) |=> $stable(ena_q));
  assert_sel_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == AW'('h08)) |=> $stable(sel_q));
  assert_ena_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'('h04)) |=> ena_q == $past(wr_data[NSRC-1:0]));
endmodule

bind dpic_top dpic_checker #(.NSRC(NSRC), .AW(AW)) u_dpic_checker (
  .clk(clk), .rst_n(rst_n), .src(src), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .fiq(fiq),
  .ena_q(ena_q), .sel_q(sel_q)
);

// File: tb/test_dpic_top.sv
`timescale 1ns/1ps
module test_dpic_top;
  localparam int NSRC = 32;
  localparam int AW = 6;

  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] src = '0;
  logic wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic irq, fiq;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  dpic_top #(.NSRC(NSRC), .AW(AW)) i_dpic_top (
    .clk(clk), .rst_n(rst_n), .src(src), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .fiq(fiq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    addr = a; rd_en = 1; #1; d = rd_data; rd_en = 0;
  endtask

  function automatic logic [31:0] top_of(logic [31:0] v);
    logic [31:0] r = 0;
    for (int i = 0; i < 32; i++) if (v[i]) r = i;
    return r;
  endfunction

  task automatic check_all(string tag, logic [31:0] e, logic [31:0] s, logic [31:0] pr);
    logic [31:0] d, en, ef;
    en = src & e & ~s; ef = src & e & s;
    rd('h00, d); chk({tag, " R2 raw"}, d, src);
    rd('h04, d); chk({tag, " R3 ena"}, d, e);
    rd('h08, d); chk({tag, " R3 sel"}, d, s);
    rd('h0C, d); chk({tag, " R4 nstat"}, d, en);
    rd('h10, d); chk({tag, " R5 fstat"}, d, ef);
    rd('h14, d); chk({tag, " R8 prio"}, d, pr);
    rd('h18, d); chk({tag, " R7 ntop"}, d, top_of(en));
    rd('h1C, d); chk({tag, " R7 ftop"}, d, top_of(ef));
    chk({tag, " R6 irq"}, irq, |en);
    chk({tag, " R6 fiq"}, fiq, |ef);
  endtask

  initial begin
    #1000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_all("R1", 0, 0, 0);
    rst_n = 1;
    @(negedge clk);
    src = 32'hFFFF_FFFF;
    check_all("R1 srcs", 0, 0, 0);
    // R10 write timing: not visible before edge
    @(negedge clk); addr = 'h04; wr_data = 32'h1234_5678; wr_en = 1;
    #1; rd_en = 1; #1; chk("R10 pre-edge", rd_data, 0); rd_en = 0;
    @(negedge clk); wr_en = 0;
    rd('h04, d); chk("R10 post-edge", d, 32'h1234_5678);
    // single-hot sweep, all enable/select combos
    for (int b = 0; b < 32; b++) begin
      for (int c = 0; c < 4; c++) begin
        logic [31:0] e, s;
        e = c[0] ? (32'h1 << b) : 32'h0;
        s = c[1] ? 32'hFFFF_FFFF : 32'h0;
        wr('h04, e); wr('h08, s);
        src = 32'h1 << b;
        check_all("R4/R5 sweep", e, s, 0);
      end
    end
    // two-hot priority
    for (int b = 1; b < 32; b++) begin
      logic [31:0] s;
      wr('h04, 32'hFFFF_FFFF);
      s = (b % 2) ? (32'h1 << b) : 32'h0;
      wr('h08, s);
      src = (32'h1 << b) | (32'h1 << (b / 2));
      check_all("R7 two-hot", 32'hFFFF_FFFF, s, 0);
    end
    // R2 live follow without clock
    src = 32'hA5A5_0F0F; rd('h00, d); chk("R2 live", d, 32'hA5A5_0F0F);
    // R8 priority scratch
    wr('h04, 32'h00FF_00FF); wr('h08, 32'h0F0F_0F0F);
    for (int b = 0; b < 32; b++) begin
      wr('h14, 32'h1 << b);
      check_all("R8 prio", 32'h00FF_00FF, 32'h0F0F_0F0F, 32'h1 << b);
    end
    // R9 writes to read-only / unmapped offsets
    for (int a = 0; a < 64; a += 4) begin
      if (a == 'h04 || a == 'h08 || a == 'h14) continue;
      wr(AW'(a), 32'hDEAD_BEEF);
      check_all("R9 ro write", 32'h00FF_00FF, 32'h0F0F_0F0F, 32'h8000_0000);
    end
    for (int a = 'h20; a < 64; a += 4) begin
      rd(AW'(a), d); chk("R9 unmapped read", d, 0);
    end
    rd('h02, d); chk("R9 unaligned read", d, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule